// File: doc/BRIEF.md
# DRAM Pattern Tester and Sizer

This block drives the command interface of a DRAM sequencer and checks a device with a fixed series of eight byte values. In single-address mode it writes each value to one chosen address, reads it back and compares it before moving to the next value. The test stops at the first mismatch and reports which value failed. In sizing mode it works out how many address lines the attached device decodes. It tries each candidate address-line count in turn, starting from a configured maximum and counting down. The first count that survives is taken as the detected size.

For each candidate count `n`, a marker byte (0x96) goes to the top address of the half-size window, `2^(n-1)-1`. The pattern series then runs at the top address of the full window, `2^n-1`. Finally the marker is read back. A device that decodes fewer than `n` lines folds both addresses onto one cell, so the pattern writes overwrite the marker and that count is rejected. The sequencer handles one command at a time: the block holds a command until the sequencer accepts it, and it waits for the read data before issuing anything else.

Top module: `dram_pattern_sizer`

## Requirements
- R1: After reset, busy, done, pass, fail_idx, det_bits, mem_size and req_valid are all 0.
- R2: In single-address mode the commands are strictly alternating: a write, then a read-back, for each of F0, 0F, AA, 55, C0, 30, 0C, 03 in that order. Every command goes to the latched test address. When all values match, exactly 16 commands are issued.
- R3: A single-address test in which all eight read-backs match ends with pass=1, fail_idx=0 and det_bits=0.
- R4: A single-address test ends at the first read-back that differs. It reports pass=0 and fail_idx equal to the position (0..7) of the failing value in the series, and issues no command after that read. The total command count is therefore 2*(fail_idx+1).
- R5: Sizing starts at min(cfg_max_bits, ADDR_W) and lowers the count by one after each rejected count. Each count issues exactly 18 commands: a marker write of 0x96 to 2^(n-1)-1, the 16 pattern commands at 2^n-1, and a read of 2^(n-1)-1. A count is rejected as soon as a pattern read-back mismatches; in that case it issues no marker read.
- R6: The first count whose patterns and marker all read back correctly is reported as det_bits. The result also sets mem_size = 2^det_bits and pass=1.
- R7: If no count from the starting value down to 1 is accepted, or cfg_max_bits is 0, sizing ends with pass=0, det_bits=0 and mem_size=0.
- R8: A start pulse while busy is ignored: it triggers neither a second run nor a second done pulse, and it does not change the mode or the address under test.
- R9: While req_valid is high and req_ready is low, the command fields stay unchanged. After a read is accepted, no new command is issued until rsp_valid returns the data.
- R10: busy rises in the cycle after an accepted start. done is a one-cycle pulse, and busy is low in that cycle.
- R11: Results hold their values after done, and no command is issued, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| start_size | input | 1 | 1 = sizing run, 0 = single-address run |
| test_addr | input | ADDR_W | Address under test in single-address mode |
| cfg_max_bits | input | CNT_W | Highest address-line count to try when sizing |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run |
| fail_idx | output | 3 | Index of the first failing value (single-address mode) |
| det_bits | output | CNT_W | Detected address-line count (0 = unset) |
| mem_size | output | ADDR_W+1 | 2^det_bits, or 0 when unset |
| req_valid | output | 1 | Command valid to the sequencer |
| req_write | output | 1 | 1 = write command, 0 = read command |
| req_addr | output | ADDR_W | Command address |
| req_wdata | output | 8 | Write data |
| req_ready | input | 1 | Sequencer accepts the command this cycle |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 8 | Read data |

## Verification
Most internal faults show up directly in the command log. A wrong series index puts the wrong write data or an extra command on the bus within one access of the fault. A wrong window count moves the marker or pattern address of the very next 18-command group. A fault in the compare or the count-down logic shows up one cycle after the last read, as a wrong fail_idx or det_bits or a wrong total number of commands. The bench models a device whose real size can be set, with upper addresses folding onto lower ones. It sweeps every real size against fixed and smaller maxima. It also runs every single-bit stuck fault and every bit-pair swap at the address under test, and compares each outcome against the failing index and command count worked out from the value series.

// File: rtl/dps_pkg.sv
// Shared constants, types and the value series for the DRAM pattern sizer.
// Assumes byte-wide data; the series length is fixed at eight.
package dps_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_PAT = 8;
    localparam int PIDX_W  = 3;

    // Marker written to the half-window top address while sizing.
    localparam logic [BYTE_W-1:0] MARKER = 8'h96;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK_WR,
        ST_PAT_WR,
        ST_PAT_RD,
        ST_MARK_RD
    } seq_state_t;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_REQ,
        AP_WAIT
    } acc_state_t;

    // Test value for a given position in the series.
    function automatic logic [BYTE_W-1:0] pat_value(input logic [PIDX_W-1:0] idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            3'd0:    v = 8'hF0;
            3'd1:    v = 8'h0F;
            3'd2:    v = 8'hAA;
            3'd3:    v = 8'h55;
            3'd4:    v = 8'hC0;
            3'd5:    v = 8'h30;
            3'd6:    v = 8'h0C;
            default: v = 8'h03;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dps_access.sv
// One-command-at-a-time access port toward the DRAM sequencer.
// Latches a command on go, holds it until req_ready, and for reads waits
// for rsp_valid. fin pulses for one cycle when the command completes.
// Assumes go is only raised while the port is idle.
module dps_access
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                go_write,
    input  logic [ADDR_W-1:0]   go_addr,
    input  logic [BYTE_W-1:0]   go_wdata,
    output logic                fin,
    output logic [BYTE_W-1:0]   fin_rdata,
    output logic                req_valid,
    output logic                req_write,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [BYTE_W-1:0]   req_wdata,
    input  logic                req_ready,
    input  logic                rsp_valid,
    input  logic [BYTE_W-1:0]   rsp_data
);

    acc_state_t          st;
    logic                a_write;
    logic [ADDR_W-1:0]   a_addr;
    logic [BYTE_W-1:0]   a_wdata;

    // Command handshake and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= AP_IDLE;
            a_write   <= 1'b0;
            a_addr    <= '0;
            a_wdata   <= '0;
            fin       <= 1'b0;
            fin_rdata <= '0;
        end else begin
            fin <= 1'b0;
            case (st)
                AP_IDLE: begin
                    if (go) begin
                        a_write <= go_write;
                        a_addr  <= go_addr;
                        a_wdata <= go_wdata;
                        st      <= AP_REQ;
                    end
                end
                AP_REQ: begin
                    if (req_ready) begin
                        if (a_write) begin
                            fin <= 1'b1;
                            st  <= AP_IDLE;
                        end else begin
                            st <= AP_WAIT;
                        end
                    end
                end
                AP_WAIT: begin
                    if (rsp_valid) begin
                        fin_rdata <= rsp_data;
                        fin       <= 1'b1;
                        st        <= AP_IDLE;
                    end
                end
                default: st <= AP_IDLE;
            endcase
        end
    end

    // Drive the command fields from the held copy.
    always_comb begin
        req_valid = (st == AP_REQ);
        req_write = a_write;
        req_addr  = a_addr;
        req_wdata = a_wdata;
    end

    // R9: a stalled command keeps its fields
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_write) && $stable(req_wdata));

    // R9: a new command is only launched when nothing is outstanding
    a_r9_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> st == AP_IDLE);

endmodule

// File: rtl/dps_window.sv
// Address window decoder: for a candidate line count n gives the top
// address of the full window (2^n-1) and of the half window (2^(n-1)-1).
// Assumes n <= ADDR_W.
module dps_window #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 4
) (
    input  logic [CNT_W-1:0]  lines,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [ADDR_W-1:0] lo_addr
);

    logic [ADDR_W-1:0] mask;

    // Thermometer mask: bit g is set when it lies below the line count.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_therm
        assign mask[g] = (CNT_W'(g) < lines);
    end

    // Half window is the full window shifted down one line.
    always_comb begin
        hi_addr = mask;
        lo_addr = mask >> 1;
    end

endmodule

// File: rtl/dps_sequencer.sv
// Test sequencer: runs the eight-value write/read/compare series at one
// address, or walks candidate line counts downward for sizing with a
// marker at the half-window top. Issues one access at a time via the
// access port and waits for its fin pulse. Results hold until next start.
module dps_sequencer
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_size,
    input  logic [ADDR_W-1:0]   test_addr,
    input  logic [CNT_W-1:0]    cfg_max_bits,
    input  logic [ADDR_W-1:0]   hi_addr,
    input  logic [ADDR_W-1:0]   lo_addr,
    output logic [CNT_W-1:0]    cur_bits,
    output logic                acc_go,
    output logic                acc_write,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic [BYTE_W-1:0]   acc_wdata,
    input  logic                acc_fin,
    input  logic [BYTE_W-1:0]   acc_rdata,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic [PIDX_W-1:0]   fail_idx,
    output logic [CNT_W-1:0]    det_bits
);

    localparam logic [CNT_W-1:0] MAX_LINES = CNT_W'(ADDR_W);

    seq_state_t          state;
    logic                size_mode;
    logic                pend;
    logic [PIDX_W-1:0]   pidx;
    logic [CNT_W-1:0]    cnt;
    logic [ADDR_W-1:0]   tst_addr;
    logic [CNT_W-1:0]    max_eff;
    logic [BYTE_W-1:0]   cur_pat;
    logic [ADDR_W-1:0]   pat_addr;
    logic                last_count;

    // Clamp the configured maximum to the address width.
    always_comb begin
        max_eff    = (cfg_max_bits > MAX_LINES) ? MAX_LINES : cfg_max_bits;
        cur_pat    = pat_value(pidx);
        pat_addr   = size_mode ? hi_addr : tst_addr;
        last_count = (cnt <= CNT_W'(1));
        cur_bits   = cnt;
    end

    // Access command for the current step.
    always_comb begin
        acc_go    = (state != ST_IDLE) && !pend;
        acc_write = 1'b0;
        acc_addr  = '0;
        acc_wdata = '0;
        case (state)
            ST_MARK_WR: begin
                acc_write = 1'b1;
                acc_addr  = lo_addr;
                acc_wdata = MARKER;
            end
            ST_PAT_WR: begin
                acc_write = 1'b1;
                acc_addr  = pat_addr;
                acc_wdata = cur_pat;
            end
            ST_PAT_RD:  acc_addr = pat_addr;
            ST_MARK_RD: acc_addr = lo_addr;
            default: ;
        endcase
    end

    // Step sequencing, comparison and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            size_mode <= 1'b0;
            pend      <= 1'b0;
            pidx      <= '0;
            cnt       <= '0;
            tst_addr  <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_idx  <= '0;
            det_bits  <= '0;
        end else begin
            done <= 1'b0;
            if (acc_go) begin
                pend <= 1'b1;
            end else if (acc_fin) begin
                pend <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pass      <= 1'b0;
                        fail_idx  <= '0;
                        det_bits  <= '0;
                        size_mode <= start_size;
                        tst_addr  <= test_addr;
                        pidx      <= '0;
                        pend      <= 1'b0;
                        if (!start_size) begin
                            busy  <= 1'b1;
                            state <= ST_PAT_WR;
                        end else if (max_eff == '0) begin
                            done <= 1'b1;
                        end else begin
                            busy  <= 1'b1;
                            cnt   <= max_eff;
                            state <= ST_MARK_WR;
                        end
                    end
                end
                ST_MARK_WR: begin
                    if (acc_fin) begin
                        pidx  <= '0;
                        state <= ST_PAT_WR;
                    end
                end
                ST_PAT_WR: begin
                    if (acc_fin) begin
                        state <= ST_PAT_RD;
                    end
                end
                ST_PAT_RD: begin
                    if (acc_fin) begin
                        if (acc_rdata == cur_pat) begin
                            if (pidx == PIDX_W'(NUM_PAT - 1)) begin
                                if (size_mode) begin
                                    state <= ST_MARK_RD;
                                end else begin
                                    pass  <= 1'b1;
                                    busy  <= 1'b0;
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end
                            end else begin
                                pidx  <= pidx + PIDX_W'(1);
                                state <= ST_PAT_WR;
                            end
                        end else if (size_mode) begin
                            if (last_count) begin
                                busy  <= 1'b0;
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                cnt   <= cnt - CNT_W'(1);
                                state <= ST_MARK_WR;
                            end
                        end else begin
                            fail_idx <= pidx;
                            busy     <= 1'b0;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_MARK_RD: begin
                    if (acc_fin) begin
                        if (acc_rdata == MARKER) begin
                            det_bits <= cnt;
                            pass     <= 1'b1;
                            busy     <= 1'b0;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else if (last_count) begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            cnt   <= cnt - CNT_W'(1);
                            state <= ST_MARK_WR;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: the done cycle never overlaps busy
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a start during a run leaves the run's setup untouched
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(size_mode) && $stable(tst_addr));

    // R7: a failed run never reports a size
    a_r7_no_size_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        done && !pass |-> det_bits == '0);

    // R5: the candidate count stays within 1..ADDR_W while sizing
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy && size_mode |-> cnt >= CNT_W'(1) && cnt <= MAX_LINES);

endmodule

// File: rtl/dram_pattern_sizer.sv
// Top of the DRAM pattern tester and sizer. Connects the sequencer, the
// address window decoder and the single-command access port, and forms
// the size output from the detected line count.
module dram_pattern_sizer
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int CNT_W = $clog2(ADDR_W + 1),
    localparam int SZ_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_size,
    input  logic [ADDR_W-1:0] test_addr,
    input  logic [CNT_W-1:0]  cfg_max_bits,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [2:0]        fail_idx,
    output logic [CNT_W-1:0]  det_bits,
    output logic [SZ_W-1:0]   mem_size,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data
);

    logic [CNT_W-1:0]  cur_bits;
    logic [ADDR_W-1:0] hi_addr;
    logic [ADDR_W-1:0] lo_addr;
    logic              acc_go;
    logic              acc_write;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_W-1:0] acc_wdata;
    logic              acc_fin;
    logic [BYTE_W-1:0] acc_rdata;

    dps_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_window (
        .lines   (cur_bits),
        .hi_addr (hi_addr),
        .lo_addr (lo_addr)
    );

    dps_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_size   (start_size),
        .test_addr    (test_addr),
        .cfg_max_bits (cfg_max_bits),
        .hi_addr      (hi_addr),
        .lo_addr      (lo_addr),
        .cur_bits     (cur_bits),
        .acc_go       (acc_go),
        .acc_write    (acc_write),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata),
        .acc_fin      (acc_fin),
        .acc_rdata    (acc_rdata),
        .busy         (busy),
        .done         (done),
        .pass         (pass),
        .fail_idx     (fail_idx),
        .det_bits     (det_bits)
    );

    dps_access #(.ADDR_W(ADDR_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (acc_go),
        .go_write  (acc_write),
        .go_addr   (acc_addr),
        .go_wdata  (acc_wdata),
        .fin       (acc_fin),
        .fin_rdata (acc_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // Size is a power of two of the detected count, zero while unset.
    always_comb begin
        mem_size = (det_bits == '0) ? '0 : (SZ_W'(1) << det_bits);
    end

    // R11: no command reaches the sequencer outside a run
    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    // R6: a successful sizing result is a single power of two
    a_r6_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        done && pass && det_bits != '0 |-> $countones(mem_size) == 1);

endmodule

// File: tb/dram_pattern_sizer_tb.sv
// Bench: behavioural DRAM with settable real size (upper address bits
// ignored), optional faults at one address, stalling ready and a
// two-cycle read latency. Sweeps faults and real sizes.
module dram_pattern_sizer_tb;

    localparam int ADDR_W = 10;
    localparam int CNT_W  = 4;
    localparam int MAXCMD = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              start_size = 1'b0;
    logic [ADDR_W-1:0] test_addr = '0;
    logic [CNT_W-1:0]  cfg_max_bits = '0;
    logic              busy, done, pass;
    logic [2:0]        fail_idx;
    logic [CNT_W-1:0]  det_bits;
    logic [ADDR_W:0]   mem_size;
    logic              req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_wdata;
    logic              req_ready;
    logic              rsp_valid = 1'b0;
    logic [7:0]        rsp_data = '0;

    dram_pattern_sizer #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_size(start_size),
        .test_addr(test_addr), .cfg_max_bits(cfg_max_bits),
        .busy(busy), .done(done), .pass(pass), .fail_idx(fail_idx),
        .det_bits(det_bits), .mem_size(mem_size),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #5 clk = ~clk;

    // ---------------- memory model ----------------
    logic [7:0]  mem [0:(1<<ADDR_W)-1];
    int          real_bits = ADDR_W;
    int          fmode = 0;          // 0 none,1 stuck0,2 stuck1,3 swap,4 dead
    int          fbit_a = 0, fbit_b = 0;
    int          fault_addr = 0;
    logic [3:0]  tick = '0;
    int          rd_cnt = 0;
    int          rd_addr = 0;

    function automatic logic [7:0] xform(input logic [7:0] v, input int a);
        logic [7:0] r;
        r = v;
        if (fmode == 4) return 8'hFF;
        if (a != fault_addr) return v;
        case (fmode)
            1: r[fbit_a] = 1'b0;
            2: r[fbit_a] = 1'b1;
            3: begin r[fbit_a] = v[fbit_b]; r[fbit_b] = v[fbit_a]; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic int eff(input logic [ADDR_W-1:0] a);
        return int'(a) & ((1 << real_bits) - 1);
    endfunction

    assign req_ready = (tick[1:0] != 2'b11);

    always_ff @(posedge clk) begin
        tick      <= tick + 4'd1;
        rsp_valid <= 1'b0;
        if (rd_cnt != 0) begin
            rd_cnt <= rd_cnt - 1;
            if (rd_cnt == 1) begin
                rsp_valid <= 1'b1;
                rsp_data  <= xform(mem[rd_addr], rd_addr);
            end
        end
        if (req_valid && req_ready) begin
            if (req_write) mem[eff(req_addr)] <= req_wdata;
            else begin
                rd_cnt  <= 2;
                rd_addr <= eff(req_addr);
            end
        end
    end

    // ---------------- monitor ----------------
    logic        log_wr   [0:MAXCMD-1];
    logic [9:0]  log_addr [0:MAXCMD-1];
    logic [7:0]  log_data [0:MAXCMD-1];
    int          ncmd = 0;
    int          ndone = 0;
    int          proto_err = 0;
    logic        outstanding = 1'b0;
    logic        prev_stall = 1'b0;
    logic [9:0]  prev_addr = '0;
    logic [7:0]  prev_data = '0;
    logic        prev_wr = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (done) ndone <= ndone + 1;
            if (prev_stall && !(req_valid && req_addr == prev_addr &&
                                req_wdata == prev_data && req_write == prev_wr))
                proto_err <= proto_err + 1;
            if (rsp_valid) outstanding <= 1'b0;
            if (req_valid && req_ready) begin
                if (outstanding) proto_err <= proto_err + 1;
                if (!req_write) outstanding <= 1'b1;
                if (ncmd < MAXCMD) begin
                    log_wr[ncmd]   <= req_write;
                    log_addr[ncmd] <= req_addr;
                    log_data[ncmd] <= req_wdata;
                end
                ncmd <= ncmd + 1;
            end
            prev_stall <= req_valid && !req_ready;
            prev_addr  <= req_addr;
            prev_data  <= req_wdata;
            prev_wr    <= req_write;
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    function automatic logic [7:0] patv(input int i);
        case (i)
            0: return 8'hF0; 1: return 8'h0F; 2: return 8'hAA; 3: return 8'h55;
            4: return 8'hC0; 5: return 8'h30; 6: return 8'h0C; default: return 8'h03;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_bench();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            finish_bench();
        end
    end

    task automatic launch(input logic sz, input int addr, input int maxb);
        @(negedge clk);
        ncmd  = 0;
        ndone = 0;
        start = 1'b1;
        start_size = sz;
        test_addr = ADDR_W'(addr);
        cfg_max_bits = CNT_W'(maxb);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check(1'b0, "R10 done timeout", t, 20000);
    endtask

    task automatic run_single(input int addr);
        launch(1'b0, addr, 0);
        wait_done();
    endtask

    task automatic run_size(input int maxb);
        launch(1'b1, 0, maxb);
        wait_done();
    endtask

    function automatic int exp_fail_idx();
        for (int i = 0; i < 8; i++)
            if (xform(patv(i), fault_addr) != patv(i)) return i;
        return 8;
    endfunction

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pass && fail_idx == 0 && det_bits == 0 &&
              mem_size == 0 && !req_valid, "R1 reset outputs",
              {busy, done, pass, req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: busy timing
        launch(1'b0, 10'h155, 0);
        check(busy, "R10 busy after start", busy, 1);
        wait_done();
        check(!busy, "R10 busy low with done", busy, 0);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);

        // R2/R3: clean single-address runs at several addresses
        for (int k = 0; k < 5; k++) begin
            int a;
            int seq_err;
            a = (k == 0) ? 0 : (k == 1) ? 10'h3FF : (k == 2) ? 10'h2AA :
                (k == 3) ? 10'h155 : 10'h0C3;
            run_single(a);
            check(pass && fail_idx == 0 && det_bits == 0, "R3 single pass", pass, 1);
            check(ncmd == 16, "R2 command count", ncmd, 16);
            seq_err = 0;
            for (int i = 0; i < 16; i++) begin
                if (log_addr[i] != 10'(a)) seq_err++;
                if (log_wr[i] != ((i % 2) == 0)) seq_err++;
                if ((i % 2) == 0 && log_data[i] != patv(i / 2)) seq_err++;
            end
            check(seq_err == 0, "R2 write/read order", seq_err, 0);
        end

        // R4: every stuck bit and bit-pair swap at the address under test
        fault_addr = 10'h2A5;
        for (int m = 1; m <= 3; m++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    int e;
                    if (m != 3 && b != 0) continue;
                    if (m == 3 && b <= a) continue;
                    fmode = m; fbit_a = a; fbit_b = b;
                    e = exp_fail_idx();
                    run_single(10'h2A5);
                    if (e == 8) begin
                        check(pass, "R3 fault-free read-back", pass, 1);
                        check(ncmd == 16, "R2 count", ncmd, 16);
                    end else begin
                        check(!pass && int'(fail_idx) == e, "R4 fail index",
                              int'(fail_idx), e);
                        repeat (8) @(negedge clk);
                        check(ncmd == 2 * (e + 1), "R4 stops at first mismatch",
                              ncmd, 2 * (e + 1));
                    end
                end
            end
        end
        fmode = 0;

        // R5/R6: sizing sweep over every real size, full maximum
        for (int k = 1; k <= ADDR_W; k++) begin
            int grp;
            int seq_err;
            real_bits = k;
            run_size(ADDR_W);
            check(pass && int'(det_bits) == k, "R6 detected count", int'(det_bits), k);
            check(int'(mem_size) == (1 << k), "R6 size", int'(mem_size), 1 << k);
            grp = ADDR_W - k + 1;
            check(ncmd == 18 * grp, "R5 command count", ncmd, 18 * grp);
            seq_err = 0;
            for (int j = 0; j < grp; j++) begin
                int n;
                n = ADDR_W - j;
                if (!log_wr[18*j] || log_data[18*j] != 8'h96 ||
                    int'(log_addr[18*j]) != (1 << (n - 1)) - 1) seq_err++;
                if (int'(log_addr[18*j+1]) != (1 << n) - 1) seq_err++;
                if (log_wr[18*j+17] || int'(log_addr[18*j+17]) != (1 << (n - 1)) - 1)
                    seq_err++;
            end
            check(seq_err == 0, "R5 marker and window addresses", seq_err, 0);
        end

        // R5/R6: maximum below the real size, and clamping above ADDR_W
        real_bits = ADDR_W;
        for (int mx = 1; mx <= 4; mx++) begin
            run_size(mx);
            check(pass && int'(det_bits) == mx, "R5 start at max", int'(det_bits), mx);
            check(ncmd == 18, "R5 single group", ncmd, 18);
        end
        real_bits = 7;
        run_size(15);
        check(pass && int'(det_bits) == 7, "R5 clamp to ADDR_W", int'(det_bits), 7);
        check(ncmd == 18 * (ADDR_W - 7 + 1), "R5 clamp group count", ncmd, 18 * 4);

        // R11: results hold, nothing issued while idle
        repeat (12) @(negedge clk);
        check(pass && int'(det_bits) == 7 && int'(mem_size) == 128 &&
              ncmd == 72 && !busy, "R11 results held", int'(det_bits), 7);

        // R7: dead device and zero maximum
        fmode = 4;
        run_size(ADDR_W);
        check(!pass && det_bits == 0 && mem_size == 0, "R7 detection failure",
              int'(det_bits), 0);
        check(ncmd == 3 * ADDR_W, "R7 count-down to 1", ncmd, 3 * ADDR_W);
        fmode = 0;
        run_size(0);
        check(!pass && det_bits == 0 && ncmd == 0, "R7 zero maximum", ncmd, 0);

        // R8: start while busy is ignored
        real_bits = ADDR_W;
        launch(1'b0, 10'h0F0, 0);
        repeat (3) @(negedge clk);
        start = 1'b1; start_size = 1'b1; cfg_max_bits = 4'd10; test_addr = 10'h001;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        check(ndone == 1, "R8 single done pulse", ndone, 1);
        check(pass && det_bits == 0 && ncmd == 16, "R8 run unchanged", ncmd, 16);
        check(log_addr[15] == 10'h0F0, "R8 address kept", int'(log_addr[15]), 10'h0F0);

        // R9: handshake protocol over the whole run
        check(proto_err == 0, "R9 hold and one outstanding", proto_err, 0);

        finish_bench();
    end

endmodule